// File: doc/BRIEF.md
# Dual-Thread Shadow-Masked Interrupt Controller

This block gathers 40 level-sensitive interrupt inputs and presents them to a processor that runs two hardware threads, driving one request line per thread. Software controls it through a 32-bit register port with separate read and write strobes, a byte address and write data. Two mask registers enable sources, and two pending registers show which enabled sources are asserting.

Most sources go to thread 0 only. A source that both threads must be able to take is paired at integration time with a spare source number, its shadow. The source's own mask bit routes it to thread 0, and the shadow's mask bit routes it to thread 1. A shadow number never acts as an interrupt of its own, so the second thread's mask needs no separate register bank. Pairs are given as two parameter lists, targets and shadows. A list that pairs a number twice, pairs a number with itself or points outside the source range stops elaboration.

Top module: `dtic_top`

## Requirements
- R1: After reset both request lines are low, read data is zero and every mask bit reads 0.
- R2: Mask bits for sources 0 to 31 live at byte offset 0x04, with source n on bit n. Mask bits for sources 32 to 39 live at offset 0x50, with source n on bit n-32. Both registers read back what was written.
- R3: Pending bits for sources 0 to 31 read at 0x08 and for sources 32 to 39 at 0x54, with the same bit numbering. A bit is 1 while its input is high and the source is enabled for either thread. Writes to these offsets change nothing.
- R4: A mask bit of 1 enables a source. Writing zero to both mask registers brings both request lines low.
- R5: The thread 0 line is high when any unpaired, non-shadow source is high and has its own mask bit set.
- R6: A paired source whose own mask bit is 0 and whose shadow's mask bit is 1 raises the thread 1 line, not the thread 0 line, and shows as pending.
- R7: A paired source with both its own and its shadow's mask bits set goes to thread 0 only.
- R8: The input of a shadow number is ignored. It never shows as pending and never raises either line, whatever its mask bit.
- R9: Bits 31:8 at 0x50 and 0x54 read as zero and ignore writes. Any other unmapped offset reads zero.
- R10: Request lines are registered. They follow a change on the inputs or the masks one clock edge later. Read data appears on the edge that samples the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 40 | Level interrupt inputs |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| irq_t0_o | output | 1 | Request line for thread 0 |
| irq_t1_o | output | 1 | Request line for thread 1 |

## Verification
Two functions can act on the same paired source in the same cycle: thread 0 routing through the source's own mask bit and thread 1 routing through the shadow's bit. The bench sets both bits while the source is high, in one vector and again in the all-ones vector. It expects only the thread 0 line to rise, with the pending bit still shown. Another vector holds a thread 1 source and a thread 0 source high together and expects both lines to rise at once.

// File: rtl/dtic_pkg.sv
package dtic_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_MASK_LO = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_PEND_LO = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_MASK_HI = 8'h50;
  localparam logic [ADDR_W-1:0] OFS_PEND_HI = 8'h54;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_MASK,
    SEL_PEND
  } rd_sel_e;
endpackage

// File: rtl/dtic_regs.sv
module dtic_regs
  import dtic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 40
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [NUM_SRC-1:0] mask_o
);
  localparam int unsigned HI_W = NUM_SRC - DATA_W;

  logic [DATA_W-1:0] mask_lo_q;
  logic [HI_W-1:0]   mask_hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_lo_q <= '0;
      mask_hi_q <= '0;
    end else if (wr_en_i) begin
      if (addr_i == OFS_MASK_LO) mask_lo_q <= wdata_i;
      if (addr_i == OFS_MASK_HI) mask_hi_q <= wdata_i[HI_W-1:0];
    end
  end

  assign mask_o = {mask_hi_q, mask_lo_q};
endmodule

// File: rtl/dtic_route.sv
module dtic_route #(
  parameter int unsigned NUM_SRC  = 40,
  parameter int unsigned PAIR_CNT = 2,
  parameter int          PAIR_TGT [PAIR_CNT] = '{30, 39},
  parameter int          PAIR_SHD [PAIR_CNT] = '{29, 38}
) (
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] mask_i,
  output logic [NUM_SRC-1:0] pend_o,
  output logic [NUM_SRC-1:0] t0_o,
  output logic [NUM_SRC-1:0] t1_o
);
  function automatic int shadow_of(int idx);
    int r = -1;
    for (int p = 0; p < int'(PAIR_CNT); p++)
      if (PAIR_TGT[p] == idx) r = PAIR_SHD[p];
    return r;
  endfunction

  function automatic bit is_shadow(int idx);
    bit r = 1'b0;
    for (int p = 0; p < int'(PAIR_CNT); p++)
      if (PAIR_SHD[p] == idx) r = 1'b1;
    return r;
  endfunction

  function automatic bit map_ok();
    bit ok = 1'b1;
    for (int p = 0; p < int'(PAIR_CNT); p++) begin
      if (PAIR_TGT[p] < 0 || PAIR_TGT[p] >= int'(NUM_SRC)) ok = 1'b0;
      if (PAIR_SHD[p] < 0 || PAIR_SHD[p] >= int'(NUM_SRC)) ok = 1'b0;
      if (PAIR_TGT[p] == PAIR_SHD[p]) ok = 1'b0;
      for (int q = p + 1; q < int'(PAIR_CNT); q++) begin
        if (PAIR_TGT[p] == PAIR_TGT[q] || PAIR_SHD[p] == PAIR_SHD[q]) ok = 1'b0;
        if (PAIR_TGT[p] == PAIR_SHD[q] || PAIR_SHD[p] == PAIR_TGT[q]) ok = 1'b0;
      end
    end
    return ok;
  endfunction

  localparam bit MAP_OK = map_ok();

  if (!MAP_OK) begin : g_bad_map
    $error("dtic_route: invalid shadow pairing");
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam int  SH    = shadow_of(i);
    localparam bit  IS_SH = is_shadow(i);
    if (IS_SH) begin : g_shadow
      // shadow number: input dropped, mask bit lent to its target
      assign t0_o[i]   = 1'b0;
      assign t1_o[i]   = 1'b0;
      assign pend_o[i] = 1'b0;
    end else if (SH >= 0) begin : g_pair
      // own bit wins so a source never reaches both threads
      assign t0_o[i]   = src_i[i] & mask_i[i];
      assign t1_o[i]   = src_i[i] & mask_i[SH] & ~mask_i[i];
      assign pend_o[i] = t0_o[i] | t1_o[i];
    end else begin : g_plain
      assign t0_o[i]   = src_i[i] & mask_i[i];
      assign t1_o[i]   = 1'b0;
      assign pend_o[i] = t0_o[i];
    end
  end
endmodule

// File: rtl/dtic_top.sv
module dtic_top
  import dtic_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 40,
  parameter int unsigned PAIR_CNT = 2,
  parameter int          PAIR_TGT [PAIR_CNT] = '{30, 39},
  parameter int          PAIR_SHD [PAIR_CNT] = '{29, 38}
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_t0_o,
  output logic               irq_t1_o
);
  localparam int unsigned HI_W  = NUM_SRC - DATA_W;
  localparam int unsigned PAD_W = DATA_W - HI_W;

  logic [NUM_SRC-1:0] mask;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] t0_vec;
  logic [NUM_SRC-1:0] t1_vec;
  logic [DATA_W-1:0]  rd_mux;
  logic [DATA_W-1:0]  rdata_q;
  logic               irq_t0_q;
  logic               irq_t1_q;

  dtic_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .mask_o  (mask)
  );

  dtic_route #(
    .NUM_SRC  (NUM_SRC),
    .PAIR_CNT (PAIR_CNT),
    .PAIR_TGT (PAIR_TGT),
    .PAIR_SHD (PAIR_SHD)
  ) u_route (
    .src_i  (src_i),
    .mask_i (mask),
    .pend_o (pend),
    .t0_o   (t0_vec),
    .t1_o   (t1_vec)
  );

  always_comb begin
    unique case (addr_i)
      OFS_MASK_LO: rd_mux = mask[DATA_W-1:0];
      OFS_PEND_LO: rd_mux = pend[DATA_W-1:0];
      OFS_MASK_HI: rd_mux = {{PAD_W{1'b0}}, mask[NUM_SRC-1:DATA_W]};
      OFS_PEND_HI: rd_mux = {{PAD_W{1'b0}}, pend[NUM_SRC-1:DATA_W]};
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      irq_t0_q <= 1'b0;
      irq_t1_q <= 1'b0;
    end else begin
      if (rd_en_i) rdata_q <= rd_mux;
      irq_t0_q <= |t0_vec;
      irq_t1_q <= |t1_vec;
    end
  end

  assign rdata_o  = rdata_q;
  assign irq_t0_o = irq_t0_q;
  assign irq_t1_o = irq_t1_q;
endmodule

// File: rtl/dtic_chk.sv
module dtic_chk
  import dtic_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 40,
  parameter int unsigned PAIR_CNT = 2,
  parameter int          PAIR_TGT [PAIR_CNT] = '{30, 39},
  parameter int          PAIR_SHD [PAIR_CNT] = '{29, 38}
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] src_i,
  input logic               rd_en_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic               irq_t0_o,
  input logic               irq_t1_o,
  input logic [NUM_SRC-1:0] mask
);
  localparam int unsigned HI_W = NUM_SRC - DATA_W;

  function automatic logic [NUM_SRC-1:0] tgt_set();
    logic [NUM_SRC-1:0] r = '0;
    for (int p = 0; p < int'(PAIR_CNT); p++) r[PAIR_TGT[p]] = 1'b1;
    return r;
  endfunction

  function automatic logic [NUM_SRC-1:0] shd_set();
    logic [NUM_SRC-1:0] r = '0;
    for (int p = 0; p < int'(PAIR_CNT); p++) r[PAIR_SHD[p]] = 1'b1;
    return r;
  endfunction

  localparam logic [NUM_SRC-1:0] TGT = tgt_set();
  localparam logic [NUM_SRC-1:0] SHD = shd_set();

  // R4
  masks_off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask == '0) |=> (!irq_t0_o && !irq_t1_o));

  // R6
  t1_needs_paired_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_t1_o |-> $past(|(src_i & TGT)));

  // R8
  t0_not_from_shadow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_t0_o |-> $past(|(src_i & ~SHD)));

  // R8
  shadow_pend_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == OFS_PEND_LO) |=> ((rdata_o & SHD[DATA_W-1:0]) == '0));

  // R9
  hi_pad_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && (addr_i == OFS_MASK_HI || addr_i == OFS_PEND_HI))
      |=> (rdata_o[DATA_W-1:HI_W] == '0));

  // R10
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

bind dtic_top dtic_chk #(
  .NUM_SRC  (NUM_SRC),
  .PAIR_CNT (PAIR_CNT),
  .PAIR_TGT (PAIR_TGT),
  .PAIR_SHD (PAIR_SHD)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .src_i    (src_i),
  .rd_en_i  (rd_en_i),
  .addr_i   (addr_i),
  .rdata_o  (rdata_o),
  .irq_t0_o (irq_t0_o),
  .irq_t1_o (irq_t1_o),
  .mask     (mask)
);

// File: tb/tb_dtic_top.sv
`timescale 1ns/1ps
module tb_dtic_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [39:0] src = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq0;
  logic        irq1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dtic_top dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .src_i    (src),
    .wr_en_i  (wr_en),
    .rd_en_i  (rd_en),
    .addr_i   (addr),
    .wdata_i  (wdata),
    .rdata_o  (rdata),
    .irq_t0_o (irq0),
    .irq_t1_o (irq1)
  );

  typedef struct packed {
    logic [39:0] src;
    logic [31:0] m_lo;
    logic [7:0]  m_hi;
    logic        e_t0;
    logic        e_t1;
    logic [31:0] p_lo;
    logic [7:0]  p_hi;
  } vec_t;

  // pairs in the default build: 30 with shadow 29, 39 with shadow 38
  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{40'h00_00000001, 32'h00000001, 8'h00, 1'b1, 1'b0, 32'h00000001, 8'h00},
    '{40'h00_00000001, 32'h00000000, 8'h00, 1'b0, 1'b0, 32'h00000000, 8'h00},
    '{40'h00_40000000, 32'h40000000, 8'h00, 1'b1, 1'b0, 32'h40000000, 8'h00},
    '{40'h00_40000000, 32'h20000000, 8'h00, 1'b0, 1'b1, 32'h40000000, 8'h00},
    '{40'h00_40000000, 32'h60000000, 8'h00, 1'b1, 1'b0, 32'h40000000, 8'h00},
    '{40'h00_20000000, 32'h20000000, 8'h00, 1'b0, 1'b0, 32'h00000000, 8'h00},
    '{40'h08_00000000, 32'h00000000, 8'h08, 1'b1, 1'b0, 32'h00000000, 8'h08},
    '{40'h80_00000000, 32'h00000000, 8'h40, 1'b0, 1'b1, 32'h00000000, 8'h80},
    '{40'h80_00000001, 32'h00000001, 8'h40, 1'b1, 1'b1, 32'h00000001, 8'h80},
    '{40'hFF_FFFFFFFF, 32'hFFFFFFFF, 8'hFF, 1'b1, 1'b0, 32'hDFFFFFFF, 8'hBF},
    '{40'h40_00000000, 32'h00000000, 8'h40, 1'b0, 1'b0, 32'h00000000, 8'h00}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 irq_t0", {31'b0, irq0}, 32'h0);
    check("R1 irq_t1", {31'b0, irq1}, 32'h0);
    check("R1 rdata", rdata, 32'h0);
    rst_n = 1'b1;
    rd(8'h04, d); check("R1 mask lo", d, 32'h0);
    rd(8'h50, d); check("R1 mask hi", d, 32'h0);

    // R2 R9 readback and padding
    wr(8'h04, 32'hA5A5_5A5A);
    rd(8'h04, d); check("R2 mask lo readback", d, 32'hA5A5_5A5A);
    wr(8'h50, 32'hFFFF_FF3C);
    rd(8'h50, d); check("R2 R9 mask hi readback", d, 32'h0000_003C);
    rd(8'h0C, d); check("R9 unmapped", d, 32'h0);
    rd(8'h54, d); check("R9 pend hi pad", d & 32'hFFFF_FF00, 32'h0);

    // R5 R6 R7 R8 R3 vector table
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      src = VECS[v].src;
      wr(8'h04, VECS[v].m_lo);
      wr(8'h50, {24'hFFFFFF, VECS[v].m_hi});
      @(negedge clk);
      check($sformatf("R5 R6 R7 R8 vec%0d irq_t0", v), {31'b0, irq0}, {31'b0, VECS[v].e_t0});
      check($sformatf("R5 R6 R7 R8 vec%0d irq_t1", v), {31'b0, irq1}, {31'b0, VECS[v].e_t1});
      rd(8'h08, d); check($sformatf("R3 vec%0d pend lo", v), d, VECS[v].p_lo);
      rd(8'h54, d); check($sformatf("R3 vec%0d pend hi", v), d, {24'h0, VECS[v].p_hi});
    end

    // R3 pending writes ignored
    @(negedge clk);
    src = 40'h00_00000001;
    wr(8'h04, 32'h1);
    wr(8'h08, 32'h0);
    wr(8'h54, 32'hFFFF_FFFF);
    rd(8'h08, d); check("R3 pend lo after write", d, 32'h1);
    rd(8'h54, d); check("R3 pend hi after write", d, 32'h0);

    // R4 mask-all with both lines active
    @(negedge clk);
    src = 40'h80_00000001;
    wr(8'h50, 32'h40);
    @(negedge clk);
    check("R4 both lines up", {30'b0, irq1, irq0}, 32'h3);
    wr(8'h04, 32'h0);
    wr(8'h50, 32'h0);
    @(negedge clk);
    check("R4 both lines down", {30'b0, irq1, irq0}, 32'h0);

    // R10 one-edge latency
    wr(8'h04, 32'h0000_0100);
    @(negedge clk);
    src = 40'h00_00000100;
    #1;
    check("R10 before edge", {31'b0, irq0}, 32'h0);
    @(negedge clk);
    check("R10 after edge", {31'b0, irq0}, 32'h1);
    src = '0;
    #1;
    check("R10 hold", {31'b0, irq0}, 32'h1);
    @(negedge clk);
    check("R10 drop", {31'b0, irq0}, 32'h0);
    rd(8'h04, d);
    @(negedge clk);
    check("R10 rdata hold", rdata, 32'h0000_0100);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule